// File: doc/BRIEF.md
# Beam position counter with packed readout

This block tracks where the raster beam is on a display. A 9-bit horizontal counter advances on each pixel-clock enable and returns to zero at the end of a line of programmable length. A 9-bit vertical counter advances each time a line ends and returns to zero at the end of a field of programmable height. When the interlace double-resolution input is high, the field height is doubled.

Each cycle, a small step decoder classifies what happens next as one of four named steps. `ADV_HOLD` means no pixel enable. `ADV_PIXEL` means the enable falls inside a line. `ADV_LINE` means the enable falls on the last pixel of a line that is not the last line. `ADV_FRAME` means the enable falls on the last pixel of the last line. Both counters act only on this step.

A read-only 16-bit port returns the position packed into two bytes. The horizontal count is halved by dropping its lowest bit. In interlace double mode the vertical count is also halved. The raw counts are exported as well.

Top module: `beam_pos_counter`

## Requirements
- R1: `h_count` increases by one on every clock edge where `pix_en` is high and the line end is not reached. It holds its value on every edge where `pix_en` is low.
- R2: On an enabled edge where `h_count + 1 >= line_len`, `h_count` returns to 0. Line lengths 0 and 1 therefore keep it at 0. Shrinking `line_len` below the current count causes a wrap on the next enabled edge.
- R3: `v_count` increases by one on exactly those edges where `h_count` wraps and the field end is not reached. It holds its value otherwise.
- R4: The field height is `frame_lines` when `ilace_dbl` = 0 and `2*frame_lines` when `ilace_dbl` = 1. On a line wrap where `v_count + 1 >=` that height, `v_count` returns to 0.
- R5: While `rst_n` is low, both counts are 0. A read during reset returns 0x0000.
- R6: Read bits [7:0] carry `h_count[8:1]`; bit 0 of the horizontal count is not reported.
- R7: With `ilace_dbl` = 0, read bits [15:8] carry `v_count[7:0]`.
- R8: With `ilace_dbl` = 1, read bits [15:8] carry `v_count[8:1]`.
- R9: `rd_data` is driven from the live counts in the same cycle that `rd_stb` is high. It is 0x0000 whenever `rd_stb` is low.
- R10: `wr_stb` has no effect: the counts and `rd_data` are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable, one pixel per high cycle |
| line_len | input | 9 | Pixels per line |
| frame_lines | input | 8 | Lines per field in normal mode |
| ilace_dbl | input | 1 | Interlace double-resolution mode |
| rd_stb | input | 1 | Read strobe for the packed position port |
| wr_stb | input | 1 | Write strobe into the port; ignored |
| rd_data | output | 16 | Packed position word, valid while `rd_stb` is high |
| h_count | output | 9 | Raw horizontal count |
| v_count | output | 9 | Raw vertical count |

## Verification
A wrong step decision shows up on `h_count` or `v_count` at the very next clock edge: a missed wrap, a double step, or a vertical advance in mid-line. A wrong field height only shows up when the last line ends, so fields are run across their end in both modes. A misrouted byte or bit shift in the packer is visible in the same cycle as the read strobe. Reads are therefore taken at counts where bit 0 and bit 8 differ from their neighbours.

// File: rtl/beam_pkg.sv
package beam_pkg;
    localparam int BYTE_W = 8;
    localparam int RD_W   = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ADV_HOLD  = 2'd0,
        ADV_PIXEL = 2'd1,
        ADV_LINE  = 2'd2,
        ADV_FRAME = 2'd3
    } adv_e;
endpackage

// File: rtl/beam_step_dec.sv
module beam_step_dec
    import beam_pkg::*;
(
    input  logic pix_en,
    input  logic h_last,
    input  logic v_last,
    output adv_e adv
);
    always_comb begin
        unique case ({pix_en, h_last, v_last})
            3'b100, 3'b101: adv = ADV_PIXEL;
            3'b110:         adv = ADV_LINE;
            3'b111:         adv = ADV_FRAME;
            default:        adv = ADV_HOLD;
        endcase
    end
endmodule

// File: rtl/beam_hcnt.sv
module beam_hcnt
    import beam_pkg::*;
#(
    parameter int H_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  adv_e           adv,
    input  logic           pix_en,
    input  logic [H_W-1:0] line_len,
    output logic [H_W-1:0] h,
    output logic           h_last
);
    localparam int EXT_W = H_W + 1;

    logic [H_W-1:0] h_nxt;

    assign h_last = ({1'b0, h} + EXT_W'(1)) >= {1'b0, line_len};

    always_comb begin
        unique case (adv)
            ADV_HOLD:             h_nxt = h;
            ADV_PIXEL:            h_nxt = h + 1'b1;
            ADV_LINE, ADV_FRAME:  h_nxt = '0;
            default:              h_nxt = h;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h <= '0;
        else        h <= h_nxt;
    end

    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pix_en && !h_last) |=> (h == $past(h) + 1'b1)); // R1
    AST_H_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !pix_en) |=> $stable(h)); // R1
    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && h_last) |=> (h == '0)); // R2
endmodule

// File: rtl/beam_vcnt.sv
module beam_vcnt
    import beam_pkg::*;
#(
    parameter int V_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  adv_e           adv,
    input  logic [V_W-2:0] frame_lines,
    input  logic           ilace_dbl,
    output logic [V_W-1:0] v,
    output logic           v_last
);
    localparam int EXT_W = V_W + 1;

    logic [V_W-1:0] v_lim;
    logic [V_W-1:0] v_nxt;

    assign v_lim  = ilace_dbl ? {frame_lines, 1'b0} : {1'b0, frame_lines};
    assign v_last = ({1'b0, v} + EXT_W'(1)) >= {1'b0, v_lim};

    always_comb begin
        unique case (adv)
            ADV_HOLD, ADV_PIXEL: v_nxt = v;
            ADV_LINE:            v_nxt = v + 1'b1;
            ADV_FRAME:           v_nxt = '0;
            default:             v_nxt = v;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v <= '0;
        else        v <= v_nxt;
    end

    AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && adv == ADV_LINE) |=> (v == $past(v) + 1'b1)); // R3
    AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (adv == ADV_HOLD || adv == ADV_PIXEL)) |=> $stable(v)); // R3
    AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv == ADV_FRAME) |=> (v == '0)); // R4
endmodule

// File: rtl/beam_rd_pack.sv
module beam_rd_pack
    import beam_pkg::*;
#(
    parameter int V_W = 9
) (
    input  logic              rd_stb,
    input  logic              ilace_dbl,
    input  logic [BYTE_W-1:0] h_hi,
    input  logic [V_W-1:0]    v,
    output logic [RD_W-1:0]   rd_data
);
    logic [BYTE_W-1:0] v_byte;

    assign v_byte  = ilace_dbl ? v[V_W-1 -: BYTE_W] : v[BYTE_W-1:0];
    assign rd_data = rd_stb ? {v_byte, h_hi} : '0;
endmodule

// File: rtl/beam_pos_counter.sv
module beam_pos_counter
    import beam_pkg::*;
#(
    parameter int H_W = 9,
    parameter int V_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_en,
    input  logic [H_W-1:0]      line_len,
    input  logic [V_W-2:0]      frame_lines,
    input  logic                ilace_dbl,
    input  logic                rd_stb,
    input  logic                wr_stb,
    output logic [RD_W-1:0]     rd_data,
    output logic [H_W-1:0]      h_count,
    output logic [V_W-1:0]      v_count
);
    adv_e adv;
    logic h_last;
    logic v_last;

    beam_step_dec u_step (
        .pix_en (pix_en),
        .h_last (h_last),
        .v_last (v_last),
        .adv    (adv)
    );

    beam_hcnt #(.H_W(H_W)) u_hcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .pix_en   (pix_en),
        .line_len (line_len),
        .h        (h_count),
        .h_last   (h_last)
    );

    beam_vcnt #(.V_W(V_W)) u_vcnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (adv),
        .frame_lines (frame_lines),
        .ilace_dbl   (ilace_dbl),
        .v           (v_count),
        .v_last      (v_last)
    );

    beam_rd_pack #(.V_W(V_W)) u_pack (
        .rd_stb    (rd_stb),
        .ilace_dbl (ilace_dbl),
        .h_hi      (h_count[H_W-1 -: BYTE_W]),
        .v         (v_count),
        .rd_data   (rd_data)
    );

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |-> (rd_data == '0)); // R9
    AST_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_stb && !pix_en) |=> ($stable(h_count) && $stable(v_count))); // R10
endmodule

// File: tb/test_beam_pos_counter.sv
module test_beam_pos_counter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pix_en;
    logic [8:0]  line_len;
    logic [7:0]  frame_lines;
    logic        ilace_dbl;
    logic        rd_stb;
    logic        wr_stb;
    logic [15:0] rd_data;
    logic [8:0]  h_count;
    logic [8:0]  v_count;

    int n_cmp = 0;
    int n_bad = 0;
    logic [8:0] mh = '0;
    logic [8:0] mv = '0;

    always #5 clk = ~clk;

    beam_pos_counter i_beam_pos_counter (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_len(line_len),
        .frame_lines(frame_lines), .ilace_dbl(ilace_dbl), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .rd_data(rd_data), .h_count(h_count), .v_count(v_count)
    );

    function automatic logic [9:0] vlim();
        return ilace_dbl ? {1'b0, frame_lines, 1'b0} : {2'b00, frame_lines};
    endfunction

    task automatic tick(input logic en);
        pix_en = en;
        @(posedge clk);
        if (rst_n && en) begin
            if ({1'b0, mh} + 10'd1 >= {1'b0, line_len}) begin
                mh = '0;
                if ({1'b0, mv} + 10'd1 >= vlim()) mv = '0;
                else mv = mv + 1'b1;
            end else begin
                mh = mh + 1'b1;
            end
        end
        @(negedge clk);
    endtask

    task automatic check_counts(input string tag);
        n_cmp++;
        if (h_count !== mh || v_count !== mv) begin
            n_bad++;
            $display("FAIL %s: h=%0d v=%0d expected h=%0d v=%0d", tag, h_count, v_count, mh, mv);
        end
    endtask

    task automatic check_read(input string tag);
        logic [15:0] exp;
        rd_stb = 1'b1;
        #1;
        exp = {(ilace_dbl ? mv[8:1] : mv[7:0]), mh[8:1]};
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected %h", tag, rd_data, exp);
        end
        rd_stb = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pix_en = 1'b1; rd_stb = 1'b0; wr_stb = 1'b0;
        line_len = 9'd10; frame_lines = 8'd5; ilace_dbl = 1'b0;
        repeat (3) @(negedge clk);
        check_counts("R5 counts held in reset");
        rd_stb = 1'b1; #1;
        n_cmp++;
        if (rd_data !== 16'h0000) begin
            n_bad++;
            $display("FAIL R5 read in reset: rd_data=%h expected 0000", rd_data);
        end
        rd_stb = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        pix_en = 1'b0;
        @(negedge clk);
        check_counts("R5 counts after reset release");
    endtask

    task automatic t_pixel_gaps();
        logic [11:0] pat = 12'b1011_0010_1110;
        for (int i = 0; i < 12; i++) begin
            tick(pat[i]);
            check_counts("R1 pixel enable gaps");
        end
    endtask

    task automatic t_normal_frame();
        line_len = 9'd10; frame_lines = 8'd5; ilace_dbl = 1'b0;
        for (int i = 0; i < 130; i++) begin
            tick(1'b1);
            check_counts("R2 R3 R4 normal field wrap");
        end
    endtask

    task automatic t_short_line();
        line_len = 9'd20;
        while (mh < 9'd8) tick(1'b1);
        line_len = 9'd3;
        tick(1'b1);
        check_counts("R2 line shrunk below count wraps");
        line_len = 9'd1;
        for (int i = 0; i < 4; i++) begin
            tick(1'b1);
            check_counts("R2 length one keeps h at 0");
        end
        line_len = 9'd0;
        tick(1'b1);
        check_counts("R2 length zero keeps h at 0");
    endtask

    task automatic t_interlace_frame();
        line_len = 9'd2; frame_lines = 8'd5; ilace_dbl = 1'b1;
        for (int i = 0; i < 50; i++) begin
            tick(1'b1);
            check_counts("R4 interlace doubled field");
        end
    endtask

    task automatic t_read_fields();
        ilace_dbl = 1'b0; line_len = 9'd400; frame_lines = 8'd250;
        for (int i = 0; i < 380; i++) begin
            tick(1'b1);
            if (i % 37 == 5) check_read("R6 R7 normal readout");
        end
        ilace_dbl = 1'b1; line_len = 9'd2; frame_lines = 8'd200;
        for (int i = 0; i < 700; i++) begin
            tick(1'b1);
            if (i % 41 == 3) check_read("R8 interlace readout");
        end
        check_counts("R8 counts after interlace run");
    endtask

    task automatic t_read_idle();
        line_len = 9'd300;
        while (mh < 9'd200) tick(1'b1);
        rd_stb = 1'b0; #1;
        n_cmp++;
        if (rd_data !== 16'h0000) begin
            n_bad++;
            $display("FAIL R9 strobe low: rd_data=%h expected 0000", rd_data);
        end
        check_read("R9 same-cycle read");
    endtask

    task automatic t_write_ignored();
        wr_stb = 1'b1;
        tick(1'b0);
        check_counts("R10 write with no pixel");
        n_cmp++;
        if (rd_data !== 16'h0000) begin
            n_bad++;
            $display("FAIL R10 write drives port: rd_data=%h expected 0000", rd_data);
        end
        for (int i = 0; i < 5; i++) begin
            tick(1'b1);
            check_counts("R10 write while counting");
        end
        check_read("R10 read during write");
        wr_stb = 1'b0;
    endtask

    initial begin
        t_reset();
        t_pixel_gaps();
        t_normal_frame();
        t_short_line();
        t_interlace_frame();
        t_read_fields();
        t_read_idle();
        t_write_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule